// File: doc/BRIEF.md
# Burst-Rate Network Injection Shaper

This block sits between a packet source and one network-on-chip link that moves one 4-byte flit per cycle. It admits flits under a two-parameter traffic envelope: a burst ceiling (sigma, in whole flits) and a sustained refill rate (rho, in 1/256 of a flit per cycle). Because the admitted traffic never exceeds that envelope, worst-case bandwidth and latency for the flow can be bounded analytically once the flow's route and envelope are fixed.

A credit register holds a fixed-point count with 8 fractional bits, where 256 counts equal one flit. Every cycle the rate is added to it, and every forwarded flit subtracts one whole flit. Both changes are applied first and the result is then clipped to the ceiling. A flit passes only while at least one whole flit of credit is held. The source side and the link side are valid/ready streams joined by combinational gating, with no buffer in between. When the link deasserts ready, the source sees ready low in the same cycle and no flit moves. A low credit also holds the source back: ready toward the source and valid toward the link both drop together. Data never changes while it waits, because the source must hold it until the handshake completes.

Top module: `burst_rate_shaper`

## Requirements
- R1: After reset the credit equals the reset burst ceiling (4 flits by default), so the first flits leave back to back. With the default rate of 64/256 and constant demand, exactly 5 flits leave in the first 5 cycles and the 6th cycle is blocked.
- R2: A flit is admitted only while credit is at least 256. While admitted, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`. While not admitted, both are 0. `out_data` always equals `in_data`.
- R3: Credit never rises above the ceiling of `burst_q` times 256. The one exception is the single cycle after a write that lowers the ceiling.
- R4: Each cycle the credit gains the rate value `rate_q`. With a rate of 64 under constant demand, the flow settles to exactly one flit every 4 cycles.
- R5: While `out_ready` is 0, `in_ready` is 0, no flit moves and no credit is spent, but refill continues up to the ceiling.
- R6: When a flit leaves in a cycle, the new credit is computed as old credit plus the rate minus 256, and only that result is clipped to the ceiling. With sigma=2 and rate=128 starting full, 3 flits leave back to back before the first blocked cycle.
- R7: A configuration write (`cfg_wr` high) loads the new sigma and rate at the clock edge. Both are used from the next cycle on, and the credit is then clipped to the new ceiling.
- R8: With sigma=0 the ceiling is zero and no flit is ever admitted.
- R9: With rate=256 under constant demand, one flit leaves every cycle indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load `cfg_burst` and `cfg_rate` at this edge |
| cfg_burst | input | BURST_W | Burst ceiling in whole flits |
| cfg_rate | input | RATE_W | Refill per cycle, in 1/256 flit |
| in_valid | input | 1 | Source has a flit |
| in_ready | output | 1 | Shaper accepts the flit this cycle |
| in_data | input | DATA_W | Source flit |
| out_valid | output | 1 | Flit offered to the link |
| out_ready | input | 1 | Link accepts a flit |
| out_data | output | DATA_W | Flit to the link |

## Verification
Refill and consumption land on the same credit register in the same cycle whenever a flit leaves. A configuration write can also coincide with the clipping that follows the next refill. Both cases are provoked by holding demand and link ready high across a burst. The bench judges them through the exact cycle-by-cycle admission pattern of a cycle-accurate credit model built from the requirements: the 3-flit burst at sigma=2 and rate=128, and the single flit after lowering sigma to 1. Each admitted cycle is checked against that model at the ports.

// File: rtl/shaper_pkg.sv
package shaper_pkg;
  localparam int SHP_FRAC_W     = 8;
  localparam int SHP_LINK_BYTES = 4;
  localparam int SHP_DATA_W     = SHP_LINK_BYTES * 8;
endpackage

// File: rtl/shaper_cfg_regs.sv
module shaper_cfg_regs #(
  parameter int BURST_W     = 6,
  parameter int RATE_W      = 9,
  parameter int RESET_BURST = 4,
  parameter int RESET_RATE  = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [BURST_W-1:0] burst_in,
  input  logic [RATE_W-1:0]  rate_in,
  output logic [BURST_W-1:0] burst_q,
  output logic [RATE_W-1:0]  rate_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= BURST_W'(RESET_BURST);
      rate_q  <= RATE_W'(RESET_RATE);
    end else if (wr) begin
      burst_q <= burst_in;
      rate_q  <= rate_in;
    end
  end
endmodule

// File: rtl/shaper_credit_acc.sv
module shaper_credit_acc #(
  parameter int BURST_W     = 6,
  parameter int RATE_W      = 9,
  parameter int FRAC_W      = 8,
  parameter int RESET_BURST = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BURST_W-1:0]        burst_q,
  input  logic [RATE_W-1:0]         rate_q,
  input  logic                      spend,
  output logic [BURST_W+FRAC_W-1:0] credit_q,
  output logic                      has_unit
);
  localparam int CRED_W = BURST_W + FRAC_W;
  localparam int SUM_W  = CRED_W + 2;
  localparam logic [SUM_W-1:0] UNIT = SUM_W'(1) << FRAC_W;

  logic [SUM_W-1:0]  ceil_w;
  logic [SUM_W-1:0]  sum_w;
  logic [CRED_W-1:0] credit_d;

  assign ceil_w   = SUM_W'({burst_q, {FRAC_W{1'b0}}});
  assign has_unit = SUM_W'(credit_q) >= UNIT;

  always_comb begin
    sum_w = SUM_W'(credit_q) + SUM_W'(rate_q) - (spend ? UNIT : '0);
    if (sum_w > ceil_w) credit_d = ceil_w[CRED_W-1:0];
    else                credit_d = sum_w[CRED_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) credit_q <= CRED_W'(RESET_BURST) << FRAC_W;
    else        credit_q <= credit_d;
  end
endmodule

// File: rtl/shaper_flow_gate.sv
module shaper_flow_gate #(
  parameter int DATA_W = 32
) (
  input  logic              allow,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              fire
);
  assign out_valid = in_valid & allow;
  assign in_ready  = out_ready & allow;
  assign out_data  = in_data;
  assign fire      = in_valid & out_ready & allow;
endmodule

// File: rtl/burst_rate_shaper.sv
module burst_rate_shaper
  import shaper_pkg::*;
#(
  parameter int DATA_W      = SHP_DATA_W,
  parameter int FRAC_W      = SHP_FRAC_W,
  parameter int BURST_W     = 6,
  parameter int RATE_W      = SHP_FRAC_W + 1,
  parameter int RESET_BURST = 4,
  parameter int RESET_RATE  = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [BURST_W-1:0] cfg_burst,
  input  logic [RATE_W-1:0]  cfg_rate,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data
);
  localparam int CRED_W = BURST_W + FRAC_W;

  logic [BURST_W-1:0] burst_q;
  logic [RATE_W-1:0]  rate_q;
  logic [CRED_W-1:0]  credit_q;
  logic               has_unit;
  logic               fire;

  shaper_cfg_regs #(
    .BURST_W(BURST_W), .RATE_W(RATE_W),
    .RESET_BURST(RESET_BURST), .RESET_RATE(RESET_RATE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
    .burst_in(cfg_burst), .rate_in(cfg_rate),
    .burst_q(burst_q), .rate_q(rate_q)
  );

  shaper_credit_acc #(
    .BURST_W(BURST_W), .RATE_W(RATE_W),
    .FRAC_W(FRAC_W), .RESET_BURST(RESET_BURST)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .burst_q(burst_q), .rate_q(rate_q),
    .spend(fire), .credit_q(credit_q), .has_unit(has_unit)
  );

  shaper_flow_gate #(.DATA_W(DATA_W)) u_gate (
    .allow(has_unit),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .fire(fire)
  );
endmodule

// File: rtl/burst_rate_shaper_chk.sv
module burst_rate_shaper_chk #(
  parameter int BURST_W = 6,
  parameter int RATE_W  = 9,
  parameter int FRAC_W  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_wr,
  input logic [BURST_W-1:0]        cfg_burst,
  input logic [RATE_W-1:0]         cfg_rate,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [BURST_W+FRAC_W-1:0] credit,
  input logic [BURST_W-1:0]        burst_q,
  input logic [RATE_W-1:0]         rate_q
);
  localparam int W = BURST_W + FRAC_W + 2;
  localparam logic [W-1:0] UNIT = W'(1) << FRAC_W;

  logic [W-1:0] ceil_w;
  logic [W-1:0] cred_w;
  logic         xfer;
  assign ceil_w = W'({burst_q, {FRAC_W{1'b0}}});
  assign cred_w = W'(credit);
  assign xfer   = out_valid & out_ready;

  p_needs_unit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> cred_w >= UNIT);

  p_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr) |-> cred_w <= ceil_w);

  p_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !cfg_wr && rate_q != 0 && cred_w < ceil_w) |=> cred_w > $past(cred_w));

  p_backpressure_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready);

  p_spend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !cfg_wr && W'(rate_q) < UNIT) |=> cred_w == $past(cred_w) + W'($past(rate_q)) - UNIT);

  p_cfg_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (burst_q == $past(cfg_burst)) && (rate_q == $past(cfg_rate)));

  p_zero_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_q == '0 && !$past(cfg_wr)) |-> !out_valid && !in_ready);

  p_accept_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> out_valid);
endmodule

bind burst_rate_shaper burst_rate_shaper_chk #(
  .BURST_W(BURST_W), .RATE_W(RATE_W), .FRAC_W(FRAC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_burst(cfg_burst),
  .cfg_rate(cfg_rate), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .credit(credit_q),
  .burst_q(burst_q), .rate_q(rate_q)
);

// File: tb/burst_rate_shaper_tb_top.sv
`timescale 1ns/1ps
module burst_rate_shaper_tb_top;
  localparam int DW = 32;
  localparam int BW = 6;
  localparam int RW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [BW-1:0] cfg_burst = '0;
  logic [RW-1:0] cfg_rate = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;

  int nchk = 0;
  int nerr = 0;
  int ncyc = 0;

  always #2 clk = ~clk;

  burst_rate_shaper dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_burst(cfg_burst),
    .cfg_rate(cfg_rate), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  // credit model written from the requirements (256 = one flit)
  int mcred, mburst, mrate;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcred <= 4 * 256; mburst <= 4; mrate <= 64;
    end else begin
      int nx;
      nx = mcred + mrate - ((in_valid && out_ready && mcred >= 256) ? 256 : 0);
      if (nx > mburst * 256) nx = mburst * 256;
      mcred <= nx;
      if (cfg_wr) begin
        mburst <= int'(cfg_burst); mrate <= int'(cfg_rate);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_wr = 0; in_valid = 0; out_ready = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // one cycle: check ports at the falling edge against the model
  task automatic cyc(input bit v, input bit r, input string tag, output bit fired);
    bit ok;
    in_valid = v; out_ready = r; in_data = in_data + 32'h01010101 + DW'(ncyc);
    @(negedge clk);
    ok = mcred >= 256;
    chk(in_ready === (r && ok), {tag, " in_ready"}, int'(in_ready), int'(r && ok));
    chk(out_valid === (v && ok), {tag, " out_valid"}, int'(out_valid), int'(v && ok));
    if (out_valid) chk(out_data === in_data, "R2 data", int'(out_data), int'(in_data));
    fired = in_valid && in_ready;
    @(posedge clk); #1;
  endtask

  task automatic run(input int n, input bit v, input bit r, input string tag, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      bit f;
      cyc(v, r, tag, f);
      cnt += int'(f);
    end
  endtask

  task automatic write_cfg(input int b, input int rt);
    cfg_wr = 1; cfg_burst = BW'(b); cfg_rate = RW'(rt);
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  task automatic t_reset_burst_r1();
    int c; bit f;
    do_reset();
    cyc(0, 0, "R1 reset", f);
    chk(out_valid === 1'b0 && in_ready === 1'b0, "R1 idle outputs", int'(out_valid), 0);
    run(5, 1, 1, "R1", c);
    chk(c == 5, "R1 initial burst", c, 5);
    cyc(1, 1, "R1", f);
    chk(f == 0, "R1 sixth blocked", int'(f), 0);
    run(2, 1, 1, "R4", c);
    run(40, 1, 1, "R4", c);
    chk(c == 10, "R4 steady rate", c, 10);
  endtask

  task automatic t_backpressure_r5();
    int c;
    do_reset();
    run(8, 1, 1, "R5 drain", c);
    run(20, 1, 0, "R5 held", c);
    chk(c == 0, "R5 no transfer while held", c, 0);
    run(5, 1, 1, "R3", c);
    chk(c == 5, "R3 R5 refill capped at ceiling", c, 5);
  endtask

  task automatic t_coincide_r6();
    int c; bit f;
    do_reset();
    write_cfg(2, 128);
    run(1, 0, 0, "R6 settle", c);
    run(3, 1, 1, "R6", c);
    chk(c == 3, "R6 burst with refill", c, 3);
    cyc(1, 1, "R6", f);
    chk(f == 0, "R6 fourth blocked", int'(f), 0);
    cyc(1, 1, "R6", f);
    chk(f == 1, "R6 fifth passes", int'(f), 1);
  endtask

  task automatic t_reconfig_r7();
    int c;
    do_reset();
    write_cfg(1, 64);
    run(1, 0, 1, "R7 old credit", c);
    run(4, 1, 1, "R7", c);
    chk(c == 1, "R7 clipped to new ceiling", c, 1);
  endtask

  task automatic t_zero_r8();
    int c;
    do_reset();
    write_cfg(0, 64);
    run(1, 0, 0, "R8 settle", c);
    run(20, 1, 1, "R8", c);
    chk(c == 0, "R8 zero ceiling blocks", c, 0);
  endtask

  task automatic t_full_rate_r9();
    int c;
    do_reset();
    write_cfg(2, 256);
    run(1, 0, 0, "R9 settle", c);
    run(50, 1, 1, "R9", c);
    chk(c == 50, "R9 one per cycle", c, 50);
  endtask

  always @(posedge clk) begin
    ncyc <= ncyc + 1;
    if (ncyc > 100000) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 100000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    t_reset_burst_r1();
    t_backpressure_r5();
    t_coincide_r6();
    t_reconfig_r7();
    t_zero_r8();
    t_full_rate_r9();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule